// File: doc/BRIEF.md
# SPI MAC-PHY Receive Frame Reassembler

This block sits on the host side of a serial-attached Ethernet MAC-PHY. The host reads receive data as fixed-size chunks. Each chunk carries a payload of `PAYLOAD_WORDS` 32-bit words followed by a 32-bit trailer. A chunk buffer presents one whole chunk at a time on `chunk_payload`/`chunk_footer`. When `chunk_ready` is high, the block accepts the chunk. It then walks the payload one byte per clock and turns the frame pieces into a byte stream with start, end and error markers.

The trailer says whether the payload carries frame data, where a new frame begins (word offset) and where the current frame ends (byte offset). It can also mark the frame that ends as bad, and it can announce that a 64-bit ingress timestamp leads the new frame. The block checks the trailer's odd parity first. It then reports the trailer's flow-control and status fields, joins frames across chunks, removes the timestamp from the byte stream and checks its parity. It also flags start/end marker sequences that do not fit together.

Top module: `mac_phy_rx_reassembler`

## Requirements
- R1: A trailer is used only when the XOR of all 32 of its bits is 1 (odd parity). A trailer that fails this check makes the following happen:
  - `footer_err` pulses in the cycle after acceptance.
  - No byte is emitted for that chunk.
  - The status outputs keep their values.
  - A frame that is open is aborted with an `rx_abort` pulse.
- R2: Every good-parity trailer updates the status outputs in the cycle after acceptance:
  - `st_ext_status` comes from bit 31.
  - `st_hdr_bad` comes from bit 30.
  - `st_synced` comes from bit 29.
  - `st_blocks_avail` comes from bits 28:24.
  - `st_tx_credits` comes from bits 5:1.
- R3: When the data-valid bit (bit 21) is 0, the chunk emits no bytes. Its start bit (20), end bit (14) and offsets are ignored, and it raises no framing error.
- R4: When data-valid and start (bit 20) are set, a frame opens at payload byte 4×SWO, where SWO is bits 19:16. `rx_sof` marks that first emitted byte. Payload byte k is `chunk_payload[8k+7:8k]`, and bytes are emitted in ascending k.
- R5: When data-valid and end (bit 14) are set, the open frame's last byte is payload byte EBO, where EBO is bits 13:8. `rx_eof` marks that byte.
- R6: A data-valid chunk with neither start nor end, arriving while a frame is open, emits all payload bytes with no `rx_sof` or `rx_eof`.
- R7: When a chunk has both markers and EBO < 4×SWO, the block first closes the old frame with bytes 0..EBO and then opens the new frame at 4×SWO.
- R8: The frame-drop bit (bit 15) sets `rx_err` on the `rx_eof` byte of the frame that ends in the chunk. Without the end bit, it has no effect.
- R9: A start that arrives while a frame is open pulses both `framing_err` and `rx_abort`. The new frame is then emitted normally.
- R10: An end that arrives with no frame open pulses `framing_err` and emits no bytes for that end.
- R11: When bit 7 is set with a start, the first 8 bytes of the new frame are a timestamp, which may cross into the next chunk. These bytes are removed from the stream. Once the eighth byte has passed, `ts_valid` pulses and `ts_value` holds the timestamp with the earliest byte in bits 63:56. `rx_sof` moves to the first byte after the timestamp.
- R12: `ts_perr` is 1 when the 64 timestamp bits together with the trailer's bit 6 hold an even number of ones.
- R13: Out of reset, `chunk_ready` is 1 and the stream is idle. A chunk that emits bytes holds `chunk_ready` low for exactly 4×`PAYLOAD_WORDS` cycles, one per payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chunk_valid | input | 1 | A chunk is presented |
| chunk_ready | output | 1 | Block is idle and takes the chunk this cycle |
| chunk_payload | input | PAYLOAD_WORDS*32 | Chunk payload, byte k at bits 8k+7:8k |
| chunk_footer | input | 32 | Chunk trailer |
| rx_valid | output | 1 | A frame byte is on rx_data |
| rx_data | output | 8 | Frame byte |
| rx_sof | output | 1 | First byte of a frame |
| rx_eof | output | 1 | Last byte of a frame |
| rx_err | output | 1 | Frame marked bad, valid with rx_eof |
| rx_abort | output | 1 | The open partial frame is discarded |
| framing_err | output | 1 | Start/end markers inconsistent with frame state |
| footer_err | output | 1 | Trailer parity failed |
| ts_valid | output | 1 | Timestamp captured |
| ts_value | output | 64 | Captured timestamp |
| ts_perr | output | 1 | Timestamp parity failed |
| st_blocks_avail | output | 5 | Chunks waiting in the device |
| st_tx_credits | output | 5 | Transmit chunks the device can take |
| st_ext_status | output | 1 | Device has pending status |
| st_hdr_bad | output | 1 | Device saw a bad command header |
| st_synced | output | 1 | Device configuration synchronized |

## Verification
The embedded assertions check properties that hold on every cycle:
- a parity-failed trailer never produces bytes and always raises `footer_err`;
- status never moves without a good trailer;
- no byte is emitted while a chunk could be accepted;
- an abort always comes with an error pulse;
- no payload byte leaks out while a timestamp is still being collected.

Only the directed scenarios can show the byte-exact content and marker placement of reassembled frames. This covers:
- frames that cross chunks;
- the close-then-open ordering;
- frame-drop routing to the right frame;
- timestamp values and parity across a chunk boundary.

// File: rtl/rxr_pkg.sv
// Shared types for the receive reassembler.
// Assumes the 32-bit trailer bit order given in the brief.
package rxr_pkg;
    localparam int FOOTER_W = 32;

    // Trailer fields used by the datapath (vendor bits and parity bit left out)
    typedef struct packed {
        logic       exst;
        logic       hdrb;
        logic       sync;
        logic [4:0] rba;
        logic       dv;
        logic       sv;
        logic [3:0] swo;
        logic       fd;
        logic       ev;
        logic [5:0] ebo;
        logic       tsa;
        logic       tsp;
        logic [4:0] txc;
    } rx_fields_t;
endpackage

// File: rtl/rxr_footer_check.sv
// Trailer decoder: splits the 32-bit trailer into named fields and checks odd parity.
// Assumes: purely combinational, the caller decides when the result is used.
module rxr_footer_check
    import rxr_pkg::*;
(
    input  logic [FOOTER_W-1:0] raw_i,
    output rx_fields_t          fields_o,
    output logic                par_ok_o
);
    // odd parity over all bits, parity bit included
    assign par_ok_o = ^raw_i;

    // field extraction by bit position
    always_comb begin
        fields_o.exst = raw_i[31];
        fields_o.hdrb = raw_i[30];
        fields_o.sync = raw_i[29];
        fields_o.rba  = raw_i[28:24];
        fields_o.dv   = raw_i[21];
        fields_o.sv   = raw_i[20];
        fields_o.swo  = raw_i[19:16];
        fields_o.fd   = raw_i[15];
        fields_o.ev   = raw_i[14];
        fields_o.ebo  = raw_i[13:8];
        fields_o.tsa  = raw_i[7];
        fields_o.tsp  = raw_i[6];
        fields_o.txc  = raw_i[5:1];
    end
endmodule

// File: rtl/rxr_chunk_walk.sv
// Chunk walker: accepts one chunk when idle and plans two byte segments
// (tail of the old frame, head of a new one). It then emits one payload byte
// per cycle with first/last/error markers, and tracks whether a frame is open.
// Assumes: the caller supplies decoded fields and parity status for the
// presented trailer; the payload is latched at acceptance.
module rxr_chunk_walk
    import rxr_pkg::*;
#(
    parameter int PAYLOAD_WORDS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        chunk_valid_i,
    input  logic [PAYLOAD_WORDS*32-1:0] chunk_payload_i,
    input  rx_fields_t                  fields_i,
    input  logic                        par_ok_i,
    output logic                        chunk_ready_o,
    output logic                        byte_valid_o,
    output logic [7:0]                  byte_data_o,
    output logic                        byte_first_o,
    output logic                        byte_last_o,
    output logic                        byte_err_o,
    output logic                        first_tsa_o,
    output logic                        first_tsp_o,
    output logic                        abort_o,
    output logic                        frame_err_o,
    output logic                        footer_err_o,
    output logic [4:0]                  st_rba_o,
    output logic [4:0]                  st_txc_o,
    output logic                        st_exst_o,
    output logic                        st_hdrb_o,
    output logic                        st_sync_o
);
    localparam int PAYLOAD_BYTES = PAYLOAD_WORDS * 4;
    localparam int IDX_W         = $clog2(PAYLOAD_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAYLOAD_BYTES - 1);

    logic                       busy_q;
    logic [IDX_W-1:0]           idx_q;
    logic [PAYLOAD_BYTES*8-1:0] pay_q;
    logic                       open_q;
    logic                       s0_en_q, s0_eof_q, s0_err_q;
    logic [IDX_W-1:0]           s0_hi_q;
    logic                       s1_en_q, s1_eof_q, s1_err_q, s1_tsa_q, s1_tsp_q;
    logic [IDX_W-1:0]           s1_lo_q, s1_hi_q;
    logic                       abort_q, ferr_q, perr_q;

    logic                       accept;
    logic                       has_start, has_end, end_first;
    logic [IDX_W-1:0]           sb, eb;
    logic                       n_s0_en, n_s0_eof, n_s1_en, n_s1_eof;
    logic [IDX_W-1:0]           n_s0_hi, n_s1_hi;
    logic                       n_ferr, n_abort, n_open;
    logic                       in0, in1;

    assign accept        = chunk_valid_i && !busy_q;
    assign chunk_ready_o = !busy_q;

    // plan the segments of the presented chunk against the current frame state
    always_comb begin
        has_start = fields_i.dv && fields_i.sv;
        has_end   = fields_i.dv && fields_i.ev;
        sb        = IDX_W'({fields_i.swo, 2'b00});
        eb        = IDX_W'(fields_i.ebo);
        end_first = has_end && (!has_start || (eb < sb));
        n_s0_en   = fields_i.dv && open_q && (!has_start || end_first);
        n_s0_hi   = end_first ? eb : LAST_IDX;
        n_s0_eof  = end_first;
        n_s1_en   = has_start;
        n_s1_eof  = has_end && !end_first;
        n_s1_hi   = n_s1_eof ? eb : LAST_IDX;
        n_ferr    = (end_first && !open_q) || (has_start && !end_first && open_q);
        n_abort   = has_start && !end_first && open_q;
        if (has_start)      n_open = !n_s1_eof;
        else if (end_first) n_open = 1'b0;
        else                n_open = open_q;
    end

    // accept a chunk, latch its plan and status, then step through the payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            idx_q    <= '0;
            pay_q    <= '0;
            open_q   <= 1'b0;
            s0_en_q  <= 1'b0;
            s0_hi_q  <= '0;
            s0_eof_q <= 1'b0;
            s0_err_q <= 1'b0;
            s1_en_q  <= 1'b0;
            s1_lo_q  <= '0;
            s1_hi_q  <= '0;
            s1_eof_q <= 1'b0;
            s1_err_q <= 1'b0;
            s1_tsa_q <= 1'b0;
            s1_tsp_q <= 1'b0;
            abort_q  <= 1'b0;
            ferr_q   <= 1'b0;
            perr_q   <= 1'b0;
            st_rba_o <= '0;
            st_txc_o <= '0;
            st_exst_o <= 1'b0;
            st_hdrb_o <= 1'b0;
            st_sync_o <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            ferr_q  <= 1'b0;
            perr_q  <= 1'b0;
            if (accept) begin
                if (!par_ok_i) begin
                    perr_q  <= 1'b1;
                    abort_q <= open_q;
                    open_q  <= 1'b0;
                    s0_en_q <= 1'b0;
                    s1_en_q <= 1'b0;
                end else begin
                    st_rba_o  <= fields_i.rba;
                    st_txc_o  <= fields_i.txc;
                    st_exst_o <= fields_i.exst;
                    st_hdrb_o <= fields_i.hdrb;
                    st_sync_o <= fields_i.sync;
                    pay_q     <= chunk_payload_i;
                    open_q    <= n_open;
                    abort_q   <= n_abort;
                    ferr_q    <= n_ferr;
                    s0_en_q   <= n_s0_en;
                    s0_hi_q   <= n_s0_hi;
                    s0_eof_q  <= n_s0_eof;
                    s0_err_q  <= n_s0_eof && fields_i.fd;
                    s1_en_q   <= n_s1_en;
                    s1_lo_q   <= sb;
                    s1_hi_q   <= n_s1_hi;
                    s1_eof_q  <= n_s1_eof;
                    s1_err_q  <= n_s1_eof && fields_i.fd;
                    s1_tsa_q  <= fields_i.tsa;
                    s1_tsp_q  <= fields_i.tsp;
                    busy_q    <= n_s0_en || n_s1_en;
                    idx_q     <= '0;
                end
            end else if (busy_q) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == LAST_IDX) busy_q <= 1'b0;
            end
        end
    end

    // classify the current byte into old-frame tail or new-frame head
    always_comb begin
        in0          = s0_en_q && (idx_q <= s0_hi_q);
        in1          = s1_en_q && (idx_q >= s1_lo_q) && (idx_q <= s1_hi_q);
        byte_valid_o = busy_q && (in0 || in1);
        byte_data_o  = pay_q[{idx_q, 3'b000} +: 8];
        byte_first_o = busy_q && in1 && (idx_q == s1_lo_q);
        byte_last_o  = busy_q && ((in0 && s0_eof_q && (idx_q == s0_hi_q)) ||
                                  (in1 && s1_eof_q && (idx_q == s1_hi_q)));
        byte_err_o   = byte_last_o && (in0 ? s0_err_q : s1_err_q);
        first_tsa_o  = s1_tsa_q;
        first_tsp_o  = s1_tsp_q;
    end

    assign abort_o      = abort_q;
    assign frame_err_o  = ferr_q;
    assign footer_err_o = perr_q;

    // R1
    bad_footer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid_i && chunk_ready_o && !par_ok_i) |=> (footer_err_o && !byte_valid_o));
    // R2
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && par_ok_i) |=> ($stable(st_rba_o) && $stable(st_txc_o)));
    // R13
    no_ready_while_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> !chunk_ready_o);
    // R9
    abort_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (frame_err_o || footer_err_o));
endmodule

// File: rtl/rxr_ts_strip.sv
// Timestamp stripper: when a frame starts with the timestamp flag set, the
// first TS_BYTES bytes of that frame are shifted into a register instead of
// being forwarded. The bytes may span chunks. Start-of-frame moves to the
// first forwarded byte. The parity of the captured value is checked against
// the trailer's timestamp parity bit.
// Assumes: a frame carrying a timestamp is longer than the timestamp.
module rxr_ts_strip #(
    parameter int TS_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid_i,
    input  logic [7:0]            in_data_i,
    input  logic                  in_first_i,
    input  logic                  in_last_i,
    input  logic                  in_err_i,
    input  logic                  in_tsa_i,
    input  logic                  in_tsp_i,
    input  logic                  abort_i,
    output logic                  out_valid_o,
    output logic [7:0]            out_data_o,
    output logic                  out_sof_o,
    output logic                  out_eof_o,
    output logic                  out_err_o,
    output logic                  ts_valid_o,
    output logic [TS_BYTES*8-1:0] ts_value_o,
    output logic                  ts_perr_o
);
    localparam int TS_W  = TS_BYTES * 8;
    localparam int CNT_W = $clog2(TS_BYTES + 1);
    localparam logic [CNT_W-1:0] TS_CNT = CNT_W'(TS_BYTES);

    logic [CNT_W-1:0] left_q, left_start;
    logic [TS_W-1:0]  shift_q, shifted;
    logic             tsp_q, tsp_now, sof_pend_q, strip;

    // decide whether this byte belongs to the timestamp or to the frame
    always_comb begin
        strip       = in_valid_i && (in_first_i ? in_tsa_i : (left_q != '0));
        left_start  = in_first_i ? TS_CNT : left_q;
        tsp_now     = in_first_i ? in_tsp_i : tsp_q;
        shifted     = {shift_q[TS_W-9:0], in_data_i};
        out_valid_o = in_valid_i && !strip;
        out_data_o  = in_data_i;
        out_sof_o   = out_valid_o && (in_first_i || sof_pend_q);
        out_eof_o   = out_valid_o && in_last_i;
        out_err_o   = out_eof_o && in_err_i;
    end

    // collect timestamp bytes and publish the value with its parity result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q     <= '0;
            shift_q    <= '0;
            tsp_q      <= 1'b0;
            sof_pend_q <= 1'b0;
            ts_valid_o <= 1'b0;
            ts_value_o <= '0;
            ts_perr_o  <= 1'b0;
        end else begin
            ts_valid_o <= 1'b0;
            if (abort_i) begin
                left_q     <= '0;
                sof_pend_q <= 1'b0;
            end
            if (strip) begin
                shift_q <= shifted;
                left_q  <= left_start - 1'b1;
                tsp_q   <= tsp_now;
                if (left_start == CNT_W'(1)) begin
                    ts_valid_o <= 1'b1;
                    ts_value_o <= shifted;
                    ts_perr_o  <= ~(^{shifted, tsp_now});
                end
            end
            if (in_valid_i && in_first_i) sof_pend_q <= in_tsa_i;
            else if (out_valid_o)         sof_pend_q <= 1'b0;
        end
    end

    // R11
    no_data_during_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !in_first_i) |-> (left_q == '0));
    // R11
    ts_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid_o |=> !ts_valid_o);
endmodule

// File: rtl/mac_phy_rx_reassembler.sv
// Top of the receive reassembler: trailer decode, chunk walk and timestamp
// stripping in series.
// Assumes: one chunk per handshake, no backpressure on the byte stream.
module mac_phy_rx_reassembler
    import rxr_pkg::*;
#(
    parameter int PAYLOAD_WORDS = 16,
    parameter int TS_BYTES      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        chunk_valid,
    output logic                        chunk_ready,
    input  logic [PAYLOAD_WORDS*32-1:0] chunk_payload,
    input  logic [31:0]                 chunk_footer,
    output logic                        rx_valid,
    output logic [7:0]                  rx_data,
    output logic                        rx_sof,
    output logic                        rx_eof,
    output logic                        rx_err,
    output logic                        rx_abort,
    output logic                        framing_err,
    output logic                        footer_err,
    output logic                        ts_valid,
    output logic [TS_BYTES*8-1:0]       ts_value,
    output logic                        ts_perr,
    output logic [4:0]                  st_blocks_avail,
    output logic [4:0]                  st_tx_credits,
    output logic                        st_ext_status,
    output logic                        st_hdr_bad,
    output logic                        st_synced
);
    rx_fields_t fields;
    logic       par_ok;
    logic       b_valid, b_first, b_last, b_err, b_tsa, b_tsp, abort_w;
    logic [7:0] b_data;

    rxr_footer_check u_check (
        .raw_i    (chunk_footer),
        .fields_o (fields),
        .par_ok_o (par_ok)
    );

    rxr_chunk_walk #(.PAYLOAD_WORDS(PAYLOAD_WORDS)) u_walk (
        .clk             (clk),
        .rst_n           (rst_n),
        .chunk_valid_i   (chunk_valid),
        .chunk_payload_i (chunk_payload),
        .fields_i        (fields),
        .par_ok_i        (par_ok),
        .chunk_ready_o   (chunk_ready),
        .byte_valid_o    (b_valid),
        .byte_data_o     (b_data),
        .byte_first_o    (b_first),
        .byte_last_o     (b_last),
        .byte_err_o      (b_err),
        .first_tsa_o     (b_tsa),
        .first_tsp_o     (b_tsp),
        .abort_o         (abort_w),
        .frame_err_o     (framing_err),
        .footer_err_o    (footer_err),
        .st_rba_o        (st_blocks_avail),
        .st_txc_o        (st_tx_credits),
        .st_exst_o       (st_ext_status),
        .st_hdrb_o       (st_hdr_bad),
        .st_sync_o       (st_synced)
    );

    rxr_ts_strip #(.TS_BYTES(TS_BYTES)) u_strip (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (b_valid),
        .in_data_i   (b_data),
        .in_first_i  (b_first),
        .in_last_i   (b_last),
        .in_err_i    (b_err),
        .in_tsa_i    (b_tsa),
        .in_tsp_i    (b_tsp),
        .abort_i     (abort_w),
        .out_valid_o (rx_valid),
        .out_data_o  (rx_data),
        .out_sof_o   (rx_sof),
        .out_eof_o   (rx_eof),
        .out_err_o   (rx_err),
        .ts_valid_o  (ts_valid),
        .ts_value_o  (ts_value),
        .ts_perr_o   (ts_perr)
    );

    assign rx_abort = abort_w;
endmodule

// File: tb/test_mac_phy_rx_reassembler.sv
// Directed bench: one task per scenario, each checking its own results.
module test_mac_phy_rx_reassembler;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         chunk_valid = 1'b0;
    logic         chunk_ready;
    logic [511:0] chunk_payload = '0;
    logic [31:0]  chunk_footer = '0;
    logic         rx_valid, rx_sof, rx_eof, rx_err, rx_abort;
    logic [7:0]   rx_data;
    logic         framing_err, footer_err, ts_valid, ts_perr;
    logic [63:0]  ts_value;
    logic [4:0]   st_blocks_avail, st_tx_credits;
    logic         st_ext_status, st_hdr_bad, st_synced;

    int tests = 0, fails = 0, cyc = 0, busy_cycles = 0;
    int c_abort = 0, c_ferr = 0, c_perr = 0, c_ts = 0;
    logic [63:0] cap_ts = '0;
    logic        cap_tsperr = 1'b0;
    logic [7:0] q_data[$], e_data[$];
    bit q_sof[$], q_eof[$], q_err[$], e_sof[$], e_eof[$], e_err[$];
    logic [4:0] g_rba = 5'd7, g_txc = 5'd3;
    bit g_exst = 1'b0, g_hdrb = 1'b0, g_sync = 1'b1;

    always #5 clk = ~clk;

    mac_phy_rx_reassembler i_mac_phy_rx_reassembler (
        .clk(clk), .rst_n(rst_n), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
        .chunk_payload(chunk_payload), .chunk_footer(chunk_footer),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_err(rx_err), .rx_abort(rx_abort), .framing_err(framing_err),
        .footer_err(footer_err), .ts_valid(ts_valid), .ts_value(ts_value),
        .ts_perr(ts_perr), .st_blocks_avail(st_blocks_avail),
        .st_tx_credits(st_tx_credits), .st_ext_status(st_ext_status),
        .st_hdr_bad(st_hdr_bad), .st_synced(st_synced)
    );

    // monitor: sample outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                q_data.push_back(rx_data);
                q_sof.push_back(rx_sof);
                q_eof.push_back(rx_eof);
                q_err.push_back(rx_err);
            end
            if (rx_abort)    c_abort++;
            if (framing_err) c_ferr++;
            if (footer_err)  c_perr++;
            if (ts_valid) begin
                c_ts++;
                cap_ts = ts_value;
                cap_tsperr = ts_perr;
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit dv, input bit sv, input logic [3:0] swo,
                                       input bit ev, input logic [5:0] ebo, input bit fd,
                                       input bit tsa, input bit tsp);
        logic [31:0] f;
        f = {g_exst, g_hdrb, g_sync, g_rba, 2'b00, dv, sv, swo, fd, ev, ebo, tsa, tsp, g_txc, 1'b0};
        f[0] = ~(^f[31:1]);
        return f;
    endfunction

    function automatic logic [511:0] mk_pay(input logic [7:0] base);
        logic [511:0] p;
        for (int k = 0; k < 64; k++) p[8*k +: 8] = base + 8'(k);
        return p;
    endfunction

    task automatic clr();
        q_data.delete(); q_sof.delete(); q_eof.delete(); q_err.delete();
        e_data.delete(); e_sof.delete(); e_eof.delete(); e_err.delete();
        c_abort = 0; c_ferr = 0; c_perr = 0; c_ts = 0;
    endtask

    task automatic exp_range(input logic [7:0] base, input int lo, input int hi,
                             input bit sof, input bit eof, input bit err);
        for (int k = lo; k <= hi; k++) begin
            e_data.push_back(base + 8'(k));
            e_sof.push_back(sof && k == lo);
            e_eof.push_back(eof && k == hi);
            e_err.push_back(err && eof && k == hi);
        end
    endtask

    task automatic compare(input string tag);
        bit ok = (q_data.size() == e_data.size());
        int bad = -1;
        if (ok) begin
            for (int k = 0; k < e_data.size(); k++) begin
                if (bad < 0 && (q_data[k] != e_data[k] || q_sof[k] != e_sof[k] ||
                                q_eof[k] != e_eof[k] || q_err[k] != e_err[k])) bad = k;
            end
        end
        if (!ok) check(1'b0, {tag, " stream length"}, q_data.size(), e_data.size());
        else if (bad >= 0)
            check(1'b0, {tag, " byte/flags at mismatch index"},
                  {q_data[bad], 3'b0, q_sof[bad], 3'b0, q_eof[bad], 3'b0, q_err[bad]},
                  {e_data[bad], 3'b0, e_sof[bad], 3'b0, e_eof[bad], 3'b0, e_err[bad]});
        else check(1'b1, tag, 0, 0);
    endtask

    task automatic send(input logic [511:0] pay, input logic [31:0] ftr);
        @(negedge clk);
        while (!chunk_ready) @(negedge clk);
        chunk_valid = 1'b1;
        chunk_payload = pay;
        chunk_footer = ftr;
        @(negedge clk);
        chunk_valid = 1'b0;
        busy_cycles = 0;
        while (!chunk_ready) begin
            busy_cycles++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(chunk_ready == 1'b1, "R13 ready after reset", chunk_ready, 1);
        check(rx_valid == 1'b0 && ts_valid == 1'b0, "R13 idle after reset", rx_valid, 0);
        check(st_blocks_avail == 0 && st_tx_credits == 0, "R2 status reset", st_blocks_avail, 0);
    endtask

    task automatic t_status();
        clr();
        g_rba = 5'd19; g_txc = 5'd11; g_exst = 1; g_hdrb = 0; g_sync = 1;
        send(mk_pay(8'h00), mk(0, 1, 4'd2, 1, 6'd5, 1, 0, 0));
        check(st_blocks_avail == 19 && st_tx_credits == 11, "R2 counts", {st_blocks_avail, st_tx_credits}, {5'd19, 5'd11});
        check({st_ext_status, st_hdr_bad, st_synced} == 3'b101, "R2 flags", {st_ext_status, st_hdr_bad, st_synced}, 3'b101);
        check(q_data.size() == 0 && c_ferr == 0, "R3 dv low ignores markers", q_data.size(), 0);
        g_rba = 5'd2; g_txc = 5'd31; g_exst = 0; g_hdrb = 1; g_sync = 0;
        send(mk_pay(8'h00), mk(0, 0, 4'd0, 0, 6'd0, 0, 0, 0));
        check(st_blocks_avail == 2 && st_tx_credits == 31 &&
              {st_ext_status, st_hdr_bad, st_synced} == 3'b010, "R2 second pattern",
              {st_blocks_avail, st_tx_credits, st_ext_status, st_hdr_bad, st_synced},
              {5'd2, 5'd31, 3'b010});
    endtask

    task automatic t_single();
        clr();
        send(mk_pay(8'h81), mk(1, 1, 4'd3, 1, 6'd40, 0, 0, 0));
        exp_range(8'h81, 12, 40, 1, 1, 0);
        compare("R4 R5 single-chunk frame");
        check(busy_cycles == 64, "R13 walk length", busy_cycles, 64);
    endtask

    task automatic t_multi();
        clr();
        send(mk_pay(8'h10), mk(1, 1, 4'd5, 0, 6'd0, 0, 0, 0));
        send(mk_pay(8'h60), mk(1, 0, 4'd0, 0, 6'd0, 0, 0, 0));
        send(mk_pay(8'hA0), mk(1, 1, 4'd4, 1, 6'd9, 1, 0, 0));
        send(mk_pay(8'h30), mk(1, 0, 4'd0, 1, 6'd63, 0, 0, 0));
        exp_range(8'h10, 20, 63, 1, 0, 0);
        exp_range(8'h60, 0, 63, 0, 0, 0);
        exp_range(8'hA0, 0, 9, 0, 1, 1);
        exp_range(8'hA0, 16, 63, 1, 0, 0);
        exp_range(8'h30, 0, 63, 0, 1, 0);
        compare("R6 R7 R8 multi-chunk frames");
        check(c_ferr == 0 && c_abort == 0, "R7 no framing error on close-then-open", c_ferr + c_abort, 0);
    endtask

    task automatic t_fd_no_end();
        clr();
        send(mk_pay(8'h40), mk(1, 1, 4'd0, 0, 6'd0, 1, 0, 0));
        send(mk_pay(8'h50), mk(1, 0, 4'd0, 1, 6'd5, 0, 0, 0));
        exp_range(8'h40, 0, 63, 1, 0, 0);
        exp_range(8'h50, 0, 5, 0, 1, 0);
        compare("R8 frame-drop without end ignored");
    endtask

    task automatic t_framing();
        clr();
        send(mk_pay(8'h99), mk(1, 0, 4'd0, 1, 6'd10, 0, 0, 0));
        check(c_ferr == 1 && q_data.size() == 0, "R10 orphan end", c_ferr, 1);
        clr();
        send(mk_pay(8'h20), mk(1, 1, 4'd1, 0, 6'd0, 0, 0, 0));
        send(mk_pay(8'h70), mk(1, 1, 4'd2, 1, 6'd30, 0, 0, 0));
        check(c_ferr == 1 && c_abort == 1, "R9 start while open", {c_ferr[7:0], c_abort[7:0]}, 16'h0101);
        exp_range(8'h20, 4, 63, 1, 0, 0);
        exp_range(8'h70, 8, 30, 1, 1, 0);
        compare("R9 new frame after abort");
    endtask

    task automatic t_bad_parity();
        logic [31:0] f;
        clr();
        g_rba = 5'd9;
        send(mk_pay(8'h11), mk(1, 1, 4'd2, 0, 6'd0, 0, 0, 0));
        f = mk(1, 0, 4'd0, 1, 6'd20, 0, 0, 0);
        f[24] = ~f[24];
        send(mk_pay(8'hE0), f);
        check(c_perr == 1 && c_abort == 1, "R1 parity error aborts", {c_perr[7:0], c_abort[7:0]}, 16'h0101);
        check(st_blocks_avail == 9, "R1 status kept", st_blocks_avail, 9);
        exp_range(8'h11, 8, 63, 1, 0, 0);
        compare("R1 no bytes from bad chunk");
        send(mk_pay(8'h00), mk(1, 0, 4'd0, 1, 6'd3, 0, 0, 0));
        check(c_ferr == 1, "R1 frame closed by bad trailer", c_ferr, 1);
    endtask

    task automatic t_ts();
        logic [63:0] tsv;
        logic [7:0]  b;
        clr();
        tsv = '0;
        for (int j = 0; j < 8; j++) tsv = {tsv[55:0], 8'h00 + 8'(4 + j)};
        send(mk_pay(8'h00), mk(1, 1, 4'd1, 1, 6'd40, 0, 1, ~(^tsv)));
        exp_range(8'h00, 12, 40, 1, 1, 0);
        compare("R11 timestamp stripped");
        check(c_ts == 1 && cap_ts == tsv, "R11 timestamp value", cap_ts, tsv);
        check(cap_tsperr == 1'b0, "R12 good timestamp parity", cap_tsperr, 0);
        clr();
        tsv = '0;
        for (int j = 0; j < 8; j++) begin
            b = (j < 4) ? 8'hC3 + 8'(60 + j) : 8'h05 + 8'(j - 4);
            tsv = {tsv[55:0], b};
        end
        send(mk_pay(8'hC3), mk(1, 1, 4'd15, 0, 6'd0, 0, 1, ^tsv));
        send(mk_pay(8'h05), mk(1, 0, 4'd0, 1, 6'd20, 0, 0, 0));
        exp_range(8'h05, 4, 20, 1, 1, 0);
        compare("R11 timestamp across chunks");
        check(c_ts == 1 && cap_ts == tsv, "R11 split timestamp value", cap_ts, tsv);
        check(cap_tsperr == 1'b1, "R12 bad timestamp parity", cap_tsperr, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status();
        t_single();
        t_multi();
        t_fd_no_end();
        t_framing();
        t_bad_parity();
        t_ts();
        summary();
        $finish;
    end
endmodule